// File: doc/BRIEF.md
# Leaf Connection Status Manager

This block holds the connection state of every leaf processor attached to one control node. Each leaf is either free or occupied by a circuit. A claim on a free leaf is granted on the spot; a claim on an occupied leaf is parked in that leaf's own first-in first-out wait list. When the circuit on a leaf is torn down, the leaf is freed if nobody is waiting. Otherwise the leaf passes straight to the oldest waiter and stays occupied.

The block also labels each claim with its allocation order. A connection from a lower processor number to a higher one is "up-going": its originator is claimed first and its destination second. Every other connection claims the destination first. The lower-numbered endpoint is therefore always taken before the higher one, so no circle of waiting claims can form. The label goes back with the response, is stored with a parked claim, and comes back out when that claim is handed the leaf.

Leaves are addressed by local numbers 0 to N_LEAF-1. Responses and hand-offs appear one clock after the inputs that cause them.

Top module: `leaf_conn_mgr`

Each leaf runs a two-state machine. The states are LEAF_IDLE and LEAF_BUSY, and the transitions are:
- CLAIM: idle to busy, on a request.
- FREE: busy to idle, on a release with an empty wait list.
- HANDOFF: busy to busy, on a release with a non-empty wait list.
- PARK: busy to busy, on a request that is queued.
- REJECT: busy to busy, on a request that finds the wait list full.

The response register takes one of four values: RESP_NONE=0, RESP_GRANT=1, RESP_QUEUED=2 and RESP_OVERFLOW=3.

## Requirements
- R1: After reset every leaf is idle, resp_kind is 0 (none) and hand_valid is 0.
- R2: A request for an idle leaf produces resp_kind=1 (grant) with resp_leaf equal to the requested leaf on the next cycle, and that leaf's bit of leaf_busy is set from then on.
- R3: A request for a busy leaf whose wait list holds fewer than Q_DEPTH entries produces resp_kind=2 (queued) on the next cycle and appends the requester node, requester leaf and up-going bit at the tail of that list.
- R4: A request for a busy leaf whose wait list is full produces resp_kind=3 (overflow) and leaves the wait list unchanged.
- R5: A release of a busy leaf whose wait list is empty clears that leaf's bit of leaf_busy on the next cycle, and hand_valid stays 0.
- R6: A release of a busy leaf whose wait list is not empty pulses hand_valid on the next cycle. hand_leaf, hand_node, hand_peer and hand_up carry the oldest entry, that entry is removed, and the leaf stays busy. Entries leave in the order they arrived.
- R7: A release of an idle leaf has no effect: no hand-off and no change to leaf_busy.
- R8: When a request and a release name the same leaf in the same cycle, the release is applied first. The request then sees the resulting state: a freed leaf, or the wait list after its head has been removed.
- R9: resp_up is 1 exactly when req_orig_num is less than req_dest_num (equal numbers give 0). The same bit is stored with a queued entry and returned as hand_up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A claim is presented this cycle |
| req_leaf | input | LEAF_W | Local leaf being claimed |
| req_node | input | NODE_W | Node of the requester |
| req_peer | input | LEAF_W | Leaf of the requester on its node |
| req_orig_num | input | NUM_W | Processor number of the connection originator |
| req_dest_num | input | NUM_W | Processor number of the connection destination |
| rel_valid | input | 1 | A release is presented this cycle |
| rel_leaf | input | LEAF_W | Local leaf being released |
| resp_kind | output | 2 | 0 none, 1 grant, 2 queued, 3 overflow |
| resp_leaf | output | LEAF_W | Leaf the response refers to |
| resp_up | output | 1 | Up-going label of the answered claim |
| hand_valid | output | 1 | A waiting claim has been given a leaf |
| hand_leaf | output | LEAF_W | Leaf handed over |
| hand_node | output | NODE_W | Node of the claim that received the leaf |
| hand_peer | output | LEAF_W | Leaf of the claim that received the leaf |
| hand_up | output | 1 | Up-going label of that claim |
| leaf_busy | output | N_LEAF | Busy flag of each leaf |

## Verification
The hardest case to reach from the ports is a release and a request on the same leaf in one cycle while that leaf's wait list is full. Only the release-first rule lets the request be queued instead of rejected. Getting there needs one grant and Q_DEPTH parked claims on a single leaf first. A directed sequence builds that state on purpose. A long pseudo-random phase then runs with only four leaves and a two-deep list, so full lists and collisions on the same leaf come up many times. A bench model derived from the requirements gives the expected value of every output in every cycle.

// File: rtl/leaf_conn_pkg.sv
package leaf_conn_pkg;
    typedef enum logic {
        LEAF_IDLE = 1'b0,
        LEAF_BUSY = 1'b1
    } leaf_state_e;

    typedef enum logic [1:0] {
        RESP_NONE     = 2'd0,
        RESP_GRANT    = 2'd1,
        RESP_QUEUED   = 2'd2,
        RESP_OVERFLOW = 2'd3
    } resp_kind_e;
endpackage

// File: rtl/leaf_order_classifier.sv
module leaf_order_classifier #(
    parameter int NUM_W = 10
) (
    input  logic [NUM_W-1:0] orig_num,
    input  logic [NUM_W-1:0] dest_num,
    output logic             upgoing
);
    // Originator is claimed first only when it carries the smaller number.
    always_comb begin
        upgoing = (orig_num < dest_num);
    end
endmodule

// File: rtl/leaf_wait_fifo.sv
module leaf_wait_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic                          pop,
    input  logic [W-1:0]                  din,
    output logic [W-1:0]                  head,
    output logic [$clog2(DEPTH+1)-1:0]    count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            if (push && !pop)      cnt_q <= cnt_q + CNT_W'(1);
            else if (pop && !push) cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign head  = mem[rd_ptr];
    assign count = cnt_q;
endmodule

// File: rtl/leaf_conn_mgr.sv
module leaf_conn_mgr #(
    parameter int N_LEAF  = 8,
    parameter int Q_DEPTH = 4,
    parameter int NODE_W  = 4,
    parameter int NUM_W   = 10,
    localparam int LEAF_W = (N_LEAF > 1) ? $clog2(N_LEAF) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [LEAF_W-1:0] req_leaf,
    input  logic [NODE_W-1:0] req_node,
    input  logic [LEAF_W-1:0] req_peer,
    input  logic [NUM_W-1:0]  req_orig_num,
    input  logic [NUM_W-1:0]  req_dest_num,
    input  logic              rel_valid,
    input  logic [LEAF_W-1:0] rel_leaf,
    output logic [1:0]        resp_kind,
    output logic [LEAF_W-1:0] resp_leaf,
    output logic              resp_up,
    output logic              hand_valid,
    output logic [LEAF_W-1:0] hand_leaf,
    output logic [NODE_W-1:0] hand_node,
    output logic [LEAF_W-1:0] hand_peer,
    output logic              hand_up,
    output logic [N_LEAF-1:0] leaf_busy
);
    import leaf_conn_pkg::*;

    localparam int ENT_W = NODE_W + LEAF_W + 1;
    localparam int CNT_W = $clog2(Q_DEPTH+1);

    leaf_state_e      st_q  [N_LEAF];
    leaf_state_e      st_nx [N_LEAF];
    logic [ENT_W-1:0] heads [N_LEAF];
    logic [CNT_W-1:0] cnts  [N_LEAF];
    logic [N_LEAF-1:0] push, pop;
    logic [ENT_W-1:0] new_entry;
    logic             req_up;

    resp_kind_e       kind_nx, kind_q;
    logic             hand_nx;
    logic [ENT_W-1:0] hand_ent_nx, hand_ent_q;
    logic [LEAF_W-1:0] resp_leaf_q, hand_leaf_q;
    logic             resp_up_q, hand_q;

    leaf_order_classifier #(.NUM_W(NUM_W)) u_order (
        .orig_num (req_orig_num),
        .dest_num (req_dest_num),
        .upgoing  (req_up)
    );

    assign new_entry = {req_node, req_peer, req_up};

    generate
        for (genvar g = 0; g < N_LEAF; g++) begin : g_leaf
            leaf_wait_fifo #(.DEPTH(Q_DEPTH), .W(ENT_W)) u_fifo (
                .clk   (clk),
                .rst_n (rst_n),
                .push  (push[g]),
                .pop   (pop[g]),
                .din   (new_entry),
                .head  (heads[g]),
                .count (cnts[g])
            );
            assign leaf_busy[g] = (st_q[g] == LEAF_BUSY);
        end
    endgenerate

    // Next-state: release is applied before the request.
    always_comb begin
        st_nx       = st_q;
        push        = '0;
        pop         = '0;
        kind_nx     = RESP_NONE;
        hand_nx     = 1'b0;
        hand_ent_nx = heads[rel_leaf];
        if (rel_valid && st_q[rel_leaf] == LEAF_BUSY) begin
            if (cnts[rel_leaf] != '0) begin
                pop[rel_leaf] = 1'b1;            // HANDOFF
                hand_nx       = 1'b1;
            end else begin
                st_nx[rel_leaf] = LEAF_IDLE;     // FREE
            end
        end
        if (req_valid) begin
            unique case (st_nx[req_leaf])
                LEAF_IDLE: begin
                    st_nx[req_leaf] = LEAF_BUSY; // CLAIM
                    kind_nx         = RESP_GRANT;
                end
                LEAF_BUSY: begin
                    if (cnts[req_leaf] < CNT_W'(Q_DEPTH) || pop[req_leaf]) begin
                        push[req_leaf] = 1'b1;   // PARK
                        kind_nx        = RESP_QUEUED;
                    end else begin
                        kind_nx        = RESP_OVERFLOW; // REJECT
                    end
                end
                default: kind_nx = RESP_NONE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_LEAF; i++) st_q[i] <= LEAF_IDLE;
        end else begin
            for (int i = 0; i < N_LEAF; i++) st_q[i] <= st_nx[i];
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q      <= RESP_NONE;
            resp_leaf_q <= '0;
            resp_up_q   <= 1'b0;
            hand_q      <= 1'b0;
            hand_leaf_q <= '0;
            hand_ent_q  <= '0;
        end else begin
            kind_q      <= kind_nx;
            resp_leaf_q <= req_leaf;
            resp_up_q   <= req_up;
            hand_q      <= hand_nx;
            hand_leaf_q <= rel_leaf;
            hand_ent_q  <= hand_ent_nx;
        end
    end

    assign resp_kind  = kind_q;
    assign resp_leaf  = resp_leaf_q;
    assign resp_up    = resp_up_q;
    assign hand_valid = hand_q;
    assign hand_leaf  = hand_leaf_q;
    assign hand_node  = hand_ent_q[ENT_W-1 -: NODE_W];
    assign hand_peer  = hand_ent_q[LEAF_W:1];
    assign hand_up    = hand_ent_q[0];
endmodule

// File: rtl/leaf_conn_mgr_chk.sv
module leaf_conn_mgr_chk #(
    parameter int N_LEAF  = 8,
    parameter int Q_DEPTH = 4,
    parameter int NODE_W  = 4,
    parameter int NUM_W   = 10,
    localparam int LEAF_W = (N_LEAF > 1) ? $clog2(N_LEAF) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [LEAF_W-1:0] req_leaf,
    input logic [NUM_W-1:0]  req_orig_num,
    input logic [NUM_W-1:0]  req_dest_num,
    input logic              rel_valid,
    input logic [LEAF_W-1:0] rel_leaf,
    input logic [1:0]        resp_kind,
    input logic [LEAF_W-1:0] resp_leaf,
    input logic              resp_up,
    input logic              hand_valid,
    input logic [LEAF_W-1:0] hand_leaf,
    input logic [N_LEAF-1:0] leaf_busy
);
    AST_GRANT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_kind == 2'd1) |-> leaf_busy[resp_leaf]); // R2

    AST_RISE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|(leaf_busy & ~$past(leaf_busy))) |-> $past(req_valid)); // R2

    AST_QUEUE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_kind == 2'd2) |-> leaf_busy[resp_leaf]); // R3

    AST_NO_OVERFLOW_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_kind == 2'd3) |-> leaf_busy[resp_leaf]); // R4

    AST_FALL_NEEDS_REL: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~leaf_busy & $past(leaf_busy))) |-> $past(rel_valid)); // R5

    AST_HAND_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        hand_valid |-> leaf_busy[hand_leaf]); // R6

    AST_HAND_NEEDS_REL: assert property (@(posedge clk) disable iff (!rst_n)
        hand_valid |-> ($past(rel_valid) && $past(rel_leaf) == hand_leaf)); // R6

    AST_UP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_kind != 2'd0) |-> (resp_up == ($past(req_orig_num) < $past(req_dest_num)))); // R9
endmodule

bind leaf_conn_mgr leaf_conn_mgr_chk #(
    .N_LEAF(N_LEAF), .Q_DEPTH(Q_DEPTH), .NODE_W(NODE_W), .NUM_W(NUM_W)
) u_chk (.*);

// File: tb/tb_leaf_conn_mgr.sv
`timescale 1ns/1ps
module tb_leaf_conn_mgr;
    localparam int NL = 4;
    localparam int QD = 2;
    localparam int NW = 3;
    localparam int MW = 6;
    localparam int LW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [LW-1:0] req_leaf = '0;
    logic [NW-1:0] req_node = '0;
    logic [LW-1:0] req_peer = '0;
    logic [MW-1:0] req_orig_num = '0;
    logic [MW-1:0] req_dest_num = '0;
    logic rel_valid = 1'b0;
    logic [LW-1:0] rel_leaf = '0;
    logic [1:0] resp_kind;
    logic [LW-1:0] resp_leaf;
    logic resp_up;
    logic hand_valid;
    logic [LW-1:0] hand_leaf;
    logic [NW-1:0] hand_node;
    logic [LW-1:0] hand_peer;
    logic hand_up;
    logic [NL-1:0] leaf_busy;

    always #5 clk = ~clk;

    leaf_conn_mgr #(.N_LEAF(NL), .Q_DEPTH(QD), .NODE_W(NW), .NUM_W(MW)) dut (.*);

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference state
    bit       mbusy [NL];
    int       mcnt  [NL];
    int       mq    [NL][QD];   // entry = node*8 + peer*2 + up

    int e_kind, e_leaf, e_up, e_hv, e_hl, e_hn, e_hp, e_hu;

    task automatic check(string rq, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic model(bit rv, int rl, int nd, int pr, int o, int d, bit lv, int ll);
        e_kind = 0; e_hv = 0; e_leaf = rl; e_up = (o < d) ? 1 : 0; e_hl = ll;
        e_hn = 0; e_hp = 0; e_hu = 0;
        if (lv && mbusy[ll]) begin
            if (mcnt[ll] > 0) begin
                e_hv = 1;
                e_hn = mq[ll][0] / 8; e_hp = (mq[ll][0] / 2) % 4; e_hu = mq[ll][0] % 2;
                for (int k = 0; k < QD-1; k++) mq[ll][k] = mq[ll][k+1];
                mcnt[ll]--;
            end else mbusy[ll] = 0;
        end
        if (rv) begin
            if (!mbusy[rl]) begin mbusy[rl] = 1; e_kind = 1; end
            else if (mcnt[rl] < QD) begin
                mq[rl][mcnt[rl]] = nd*8 + pr*2 + e_up; mcnt[rl]++; e_kind = 2;
            end else e_kind = 3;
        end
    endtask

    task automatic step(bit rv, int rl, int nd, int pr, int o, int d, bit lv, int ll, string rq);
        @(negedge clk);
        req_valid = rv; req_leaf = LW'(rl); req_node = NW'(nd); req_peer = LW'(pr);
        req_orig_num = MW'(o); req_dest_num = MW'(d);
        rel_valid = lv; rel_leaf = LW'(ll);
        model(rv, rl, nd, pr, o, d, lv, ll);
        @(posedge clk); #1;
        check({rq, " kind"}, int'(resp_kind), e_kind);
        if (e_kind != 0) begin
            check({rq, " R2 leaf"}, int'(resp_leaf), e_leaf);
            check({rq, " R9 up"}, int'(resp_up), e_up);
        end
        check({rq, " R6 hand_valid"}, int'(hand_valid), e_hv);
        if (e_hv != 0) begin
            check({rq, " R6 hand_leaf"}, int'(hand_leaf), e_hl);
            check({rq, " R6 hand_node"}, int'(hand_node), e_hn);
            check({rq, " R6 hand_peer"}, int'(hand_peer), e_hp);
            check({rq, " R9 hand_up"}, int'(hand_up), e_hu);
        end
        for (int i = 0; i < NL; i++)
            check({rq, " busy"}, int'(leaf_busy[i]), int'(mbusy[i]));
    endtask

    initial begin
        logic [15:0] lf;
        for (int i = 0; i < NL; i++) begin mbusy[i] = 0; mcnt[i] = 0; end
        repeat (3) @(posedge clk);
        #1;
        check("R1 kind", int'(resp_kind), 0);
        check("R1 hand", int'(hand_valid), 0);
        check("R1 busy", int'(leaf_busy), 0);
        @(negedge clk); rst_n = 1'b1;
        // R2 grant, up-going and not
        step(1, 0, 1, 2, 3, 9, 0, 0, "R2");
        step(1, 1, 2, 0, 9, 3, 0, 0, "R2");
        // R3 queue two on leaf 0, R9 equal numbers -> 0
        step(1, 0, 5, 3, 7, 7, 0, 0, "R3");
        step(1, 0, 6, 1, 1, 2, 0, 0, "R3");
        // R4 overflow
        step(1, 0, 7, 2, 4, 5, 0, 0, "R4");
        // R8 release + request same leaf, full list
        step(1, 0, 3, 3, 2, 1, 1, 0, "R8");
        // R6 hand-offs in order
        step(0, 0, 0, 0, 0, 0, 1, 0, "R6");
        step(0, 0, 0, 0, 0, 0, 1, 0, "R6");
        // R5 free
        step(0, 0, 0, 0, 0, 0, 1, 0, "R5");
        // R7 release idle leaf
        step(0, 0, 0, 0, 0, 0, 1, 2, "R7");
        step(0, 0, 0, 0, 0, 0, 1, 0, "R7");
        // R8 release frees, request same leaf gets grant
        step(0, 0, 0, 0, 0, 0, 1, 1, "R5");
        step(1, 3, 1, 1, 1, 1, 0, 0, "R2");
        step(1, 3, 2, 2, 0, 5, 1, 3, "R8");
        // Pseudo-random sweep
        lf = 16'hACE1;
        for (int c = 0; c < 6000; c++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0] | lf[1], int'(lf[3:2]), int'(lf[6:4]), int'(lf[8:7]),
                 int'(lf[11:9]), int'(lf[14:12]), lf[15] & (lf[5] | lf[9]), int'(lf[11:10]), "RND");
        end
        @(negedge clk); req_valid = 0; rel_valid = 0;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule